// File: doc/BRIEF.md
# Nickel Charge Termination Detector

This block decides when a fast charge of a nickel pack should stop. It takes two sample streams, each a signed integer code with a valid strobe. The first is the average voltage of a single cell. The second is the battery temperature. The block runs two criteria in parallel:

- **Voltage drop:** a peak-hold detector fires once the cell voltage has fallen far enough below its running maximum.
- **Temperature slope:** a detector compares the temperature at each one-minute strobe with the value taken at the previous strobe.

Configuration inputs set the limits and decide which criterion may fire. They are:

- the chemistry (NiCd or NiMH);
- whether a thermistor is fitted;
- pause;
- whether the initial cell voltage was high;
- whether the stabilization window is still open;
- whether the cycle was started from automatic recharge.

The charge sequencer pulses `start_i` at the beginning of each fast charge. It then waits for `term_o`, and reads `reason_o` to learn which criterion ended the charge. The reason stays latched until the sequencer pulses `clr_i`.

Scaling: one voltage code equals 1 mV per cell. One temperature code equals 0.1 °C.

Top module: `nickel_term_detect`

## Requirements
- R1: The voltage-drop limit is 20 codes when `chem_nimh_i`=0 (NiCd) and 10 codes when `chem_nimh_i`=1 (NiMH).
- R2: After `start_i` or reset, the first accepted `v_valid_i` sample only loads the peak. After that the peak changes only on a strictly higher sample. A drop fires when peak minus sample is at least the limit.
- R3: While `stab_i`=1, the drop criterion cannot fire, unless `init_high_i`=1 or `from_rchg_i`=1.
- R4: On each `minute_i`, the latest `t_code_i` sample minus the reference is compared with the slope limit, and the reference then takes the latest sample. The first strobe after `start_i` only sets the reference.
- R5: The slope limit is 20 codes for NiCd. For NiMH it is 15 codes while `stab_i`=1, `init_high_i`=0 and `from_rchg_i`=0, and 10 codes otherwise (always 10 when `from_rchg_i`=1). A slope fires when the rise is at least the limit.
- R6: The slope criterion fires only while `therm_i`=1.
- R7: While `pause_i`=1, neither criterion fires. Voltage samples leave the peak untouched, and minute strobes leave the reference untouched.
- R8: `term_o` is high for the single cycle that follows the clock edge that took the firing sample or strobe. `reason_o` is 2'b01 for a voltage drop and 2'b10 for a slope, and it is never 2'b11. If both criteria fire together, the voltage drop wins.
- R9: A nonzero `reason_o` holds and blocks further `term_o` pulses until `clr_i`. `clr_i` sets `reason_o` to 2'b00 and wins over a criterion firing in the same cycle.
- R10: Reset drives `term_o` low and `reason_o` to 2'b00, and clears the peak and the reference.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Fast charge begins; clears peak and reference |
| chem_nimh_i | input | 1 | 1 = NiMH, 0 = NiCd |
| therm_i | input | 1 | Thermistor fitted |
| pause_i | input | 1 | Inhibit both criteria |
| init_high_i | input | 1 | Initial cell voltage was above the recharge level |
| stab_i | input | 1 | Stabilization window open |
| from_rchg_i | input | 1 | Cycle started from automatic recharge |
| v_valid_i | input | 1 | Voltage sample strobe |
| v_code_i | input | SW | Signed cell-voltage code |
| t_valid_i | input | 1 | Temperature sample strobe |
| t_code_i | input | TW | Signed temperature code |
| minute_i | input | 1 | One-minute strobe |
| clr_i | input | 1 | Clear latched reason |
| term_o | output | 1 | Terminate pulse |
| reason_o | output | 2 | Criterion that fired |

## Verification
The bench uses the default parameters: SW=12, TW=10, drop limits 20 and 10, and slope limits 20, 15 and 10. With these values every threshold falls on small integers, so each limit can be hit exactly and also missed by one code. The stimulus table walks each chemistry and phase combination through a below-limit step and an at-limit step. Directed tests then cover:

- an absent thermistor;
- pause during slope tracking;
- both criteria firing in the same cycle;
- a clear that collides with a firing sample;
- a reset in the middle of a run.

// File: rtl/nt_pkg.sv
package nt_pkg;
  typedef enum logic [1:0] {
    RSN_NONE  = 2'b00,
    RSN_DROP  = 2'b01,
    RSN_SLOPE = 2'b10
  } rsn_e;
endpackage

// File: rtl/nt_limit_sel.sv
module nt_limit_sel #(
  parameter int LIM_W        = 6,
  parameter int DROP_NICD    = 20,
  parameter int DROP_NIMH    = 10,
  parameter int SLOPE_NICD   = 20,
  parameter int SLOPE_NIMH   = 10,
  parameter int SLOPE_NIMH_E = 15
) (
  input  logic             chem_nimh_i,
  input  logic             stab_i,
  input  logic             init_high_i,
  input  logic             from_rchg_i,
  output logic [LIM_W-1:0] drop_lim_o,
  output logic [LIM_W-1:0] slope_lim_o
);
  localparam logic [LIM_W-1:0] DL_CD = LIM_W'(DROP_NICD);
  localparam logic [LIM_W-1:0] DL_MH = LIM_W'(DROP_NIMH);
  localparam logic [LIM_W-1:0] SL_CD = LIM_W'(SLOPE_NICD);
  localparam logic [LIM_W-1:0] SL_MH = LIM_W'(SLOPE_NIMH);
  localparam logic [LIM_W-1:0] SL_ME = LIM_W'(SLOPE_NIMH_E);

  logic early;
  // relaxed NiMH slope only in a fresh cycle that started low
  assign early = stab_i && !init_high_i && !from_rchg_i;

  always_comb begin
    drop_lim_o = chem_nimh_i ? DL_MH : DL_CD;
    if (!chem_nimh_i)  slope_lim_o = SL_CD;
    else if (early)    slope_lim_o = SL_ME;
    else               slope_lim_o = SL_MH;
  end
endmodule

// File: rtl/nt_peak_drop.sv
module nt_peak_drop #(
  parameter int SW    = 12,
  parameter int LIM_W = 6
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 start_i,
  input  logic                 valid_i,
  input  logic signed [SW-1:0] sample_i,
  input  logic                 pause_i,
  input  logic                 en_i,
  input  logic [LIM_W-1:0]     lim_i,
  output logic                 hit_o
);
  localparam int DW = SW + 1;

  logic signed [SW-1:0] pk_q;
  logic                 have_q;
  logic signed [DW-1:0] diff, lim_x;
  logic                 take;

  assign take  = valid_i && !pause_i;
  assign diff  = DW'(pk_q) - DW'(sample_i);
  assign lim_x = $signed({{(DW-LIM_W){1'b0}}, lim_i});
  assign hit_o = take && have_q && en_i && (diff >= lim_x);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pk_q   <= '0;
      have_q <= 1'b0;
    end else if (start_i) begin
      have_q <= 1'b0;
    end else if (take) begin
      if (!have_q || (sample_i > pk_q)) pk_q <= sample_i;
      have_q <= 1'b1;
    end
  end
endmodule

// File: rtl/nt_slope.sv
module nt_slope #(
  parameter int TW    = 10,
  parameter int LIM_W = 6
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 start_i,
  input  logic                 valid_i,
  input  logic signed [TW-1:0] sample_i,
  input  logic                 minute_i,
  input  logic                 pause_i,
  input  logic                 en_i,
  input  logic [LIM_W-1:0]     lim_i,
  output logic                 hit_o
);
  localparam int DW = TW + 1;

  logic signed [TW-1:0] last_q, ref_q;
  logic                 last_v_q, ref_v_q;
  logic signed [DW-1:0] rise, lim_x;
  logic                 tick;

  assign tick  = minute_i && !pause_i && last_v_q;
  assign rise  = DW'(last_q) - DW'(ref_q);
  assign lim_x = $signed({{(DW-LIM_W){1'b0}}, lim_i});
  assign hit_o = tick && ref_v_q && en_i && (rise >= lim_x);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      last_q   <= '0;
      last_v_q <= 1'b0;
      ref_q    <= '0;
      ref_v_q  <= 1'b0;
    end else if (start_i) begin
      last_v_q <= 1'b0;
      ref_v_q  <= 1'b0;
    end else begin
      if (valid_i) begin
        last_q   <= sample_i;
        last_v_q <= 1'b1;
      end
      if (tick) begin
        ref_q   <= last_q;
        ref_v_q <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/nickel_term_detect.sv
module nickel_term_detect
  import nt_pkg::*;
#(
  parameter int SW           = 12,
  parameter int TW           = 10,
  parameter int LIM_W        = 6,
  parameter int DROP_NICD    = 20,
  parameter int DROP_NIMH    = 10,
  parameter int SLOPE_NICD   = 20,
  parameter int SLOPE_NIMH   = 10,
  parameter int SLOPE_NIMH_E = 15
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          chem_nimh_i,
  input  logic          therm_i,
  input  logic          pause_i,
  input  logic          init_high_i,
  input  logic          stab_i,
  input  logic          from_rchg_i,
  input  logic          v_valid_i,
  input  logic [SW-1:0] v_code_i,
  input  logic          t_valid_i,
  input  logic [TW-1:0] t_code_i,
  input  logic          minute_i,
  input  logic          clr_i,
  output logic          term_o,
  output logic [1:0]    reason_o
);
  logic [LIM_W-1:0] drop_lim, slope_lim;
  logic             drop_en, slope_en, drop_hit, slope_hit;
  rsn_e             rsn_q;
  logic             term_q;

  assign drop_en  = from_rchg_i || init_high_i || !stab_i;
  assign slope_en = therm_i;

  nt_limit_sel #(
    .LIM_W(LIM_W), .DROP_NICD(DROP_NICD), .DROP_NIMH(DROP_NIMH),
    .SLOPE_NICD(SLOPE_NICD), .SLOPE_NIMH(SLOPE_NIMH), .SLOPE_NIMH_E(SLOPE_NIMH_E)
  ) u_lim (
    .chem_nimh_i(chem_nimh_i), .stab_i(stab_i), .init_high_i(init_high_i),
    .from_rchg_i(from_rchg_i), .drop_lim_o(drop_lim), .slope_lim_o(slope_lim)
  );

  nt_peak_drop #(.SW(SW), .LIM_W(LIM_W)) u_drop (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .valid_i(v_valid_i),
    .sample_i(v_code_i), .pause_i(pause_i), .en_i(drop_en), .lim_i(drop_lim),
    .hit_o(drop_hit)
  );

  nt_slope #(.TW(TW), .LIM_W(LIM_W)) u_slope (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .valid_i(t_valid_i),
    .sample_i(t_code_i), .minute_i(minute_i), .pause_i(pause_i), .en_i(slope_en),
    .lim_i(slope_lim), .hit_o(slope_hit)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsn_q  <= RSN_NONE;
      term_q <= 1'b0;
    end else if (clr_i) begin
      rsn_q  <= RSN_NONE;
      term_q <= 1'b0;
    end else if (rsn_q == RSN_NONE && (drop_hit || slope_hit)) begin
      rsn_q  <= drop_hit ? RSN_DROP : RSN_SLOPE;
      term_q <= 1'b1;
    end else begin
      term_q <= 1'b0;
    end
  end

  assign term_o   = term_q;
  assign reason_o = rsn_q;
endmodule

// File: rtl/nt_term_checker.sv
module nt_term_checker (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       pause_i,
  input logic       therm_i,
  input logic       v_valid_i,
  input logic       minute_i,
  input logic       clr_i,
  input logic       term_o,
  input logic [1:0] reason_o
);
  p_code_legal_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reason_o != 2'b11);
  p_term_reason_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    term_o |-> reason_o != 2'b00);
  p_single_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    term_o |=> !term_o);
  p_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reason_o != 2'b00 && !clr_i) |=> $stable(reason_o));
  p_clear_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (reason_o == 2'b00 && !term_o));
  p_pause_quiet_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pause_i |=> !term_o);
  p_no_therm_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!therm_i && !v_valid_i) |=> !term_o);
  p_minute_only_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!minute_i && !v_valid_i) |=> !term_o);
endmodule

bind nickel_term_detect nt_term_checker u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .pause_i(pause_i), .therm_i(therm_i),
  .v_valid_i(v_valid_i), .minute_i(minute_i), .clr_i(clr_i),
  .term_o(term_o), .reason_o(reason_o)
);

// File: tb/nickel_term_detect_tb.sv
module nickel_term_detect_tb;
  localparam int SW = 12;
  localparam int TW = 10;

  localparam logic [2:0] OP_START = 3'd0, OP_V = 3'd1, OP_T = 3'd2, OP_MIN = 3'd3,
                         OP_CLR = 3'd4, OP_VM = 3'd5, OP_VC = 3'd6, OP_IDLE = 3'd7;

  // cfg = {chem_nimh, therm, stab, init_high, from_rchg, pause}
  typedef struct packed {
    logic [2:0]        op;
    logic [5:0]        cfg;
    logic signed [11:0] val;
    logic              et;
    logic [1:0]        er;
    logic [7:0]        req;
  } vec_t;

  localparam int NV = 58;
  localparam vec_t VEC [NV] = '{
    '{OP_START, 6'b110000, 12'sd0,    1'b0, 2'b00, 8'd10},
    '{OP_V,     6'b110000, 12'sd1400, 1'b0, 2'b00, 8'd2},  // R2 load
    '{OP_V,     6'b110000, 12'sd1410, 1'b0, 2'b00, 8'd2},
    '{OP_V,     6'b110000, 12'sd1401, 1'b0, 2'b00, 8'd1},  // R1 NiMH 9
    '{OP_V,     6'b110000, 12'sd1400, 1'b1, 2'b01, 8'd1},  // R1 NiMH 10
    '{OP_V,     6'b110000, 12'sd1380, 1'b0, 2'b01, 8'd9},  // R9 latched
    '{OP_CLR,   6'b110000, 12'sd0,    1'b0, 2'b00, 8'd9},
    '{OP_START, 6'b010000, 12'sd0,    1'b0, 2'b00, 8'd1},
    '{OP_V,     6'b010000, 12'sd1400, 1'b0, 2'b00, 8'd2},
    '{OP_V,     6'b010000, 12'sd1381, 1'b0, 2'b00, 8'd1},  // R1 NiCd 19
    '{OP_V,     6'b010000, 12'sd1380, 1'b1, 2'b01, 8'd1},  // R1 NiCd 20
    '{OP_CLR,   6'b010000, 12'sd0,    1'b0, 2'b00, 8'd9},
    '{OP_START, 6'b111000, 12'sd0,    1'b0, 2'b00, 8'd3},
    '{OP_V,     6'b111000, 12'sd1400, 1'b0, 2'b00, 8'd3},
    '{OP_V,     6'b111000, 12'sd1350, 1'b0, 2'b00, 8'd3},  // R3 held off
    '{OP_V,     6'b111100, 12'sd1350, 1'b1, 2'b01, 8'd3},  // R3 init high
    '{OP_CLR,   6'b111000, 12'sd0,    1'b0, 2'b00, 8'd9},
    '{OP_START, 6'b111000, 12'sd0,    1'b0, 2'b00, 8'd3},
    '{OP_V,     6'b111000, 12'sd1400, 1'b0, 2'b00, 8'd3},
    '{OP_V,     6'b111010, 12'sd1350, 1'b1, 2'b01, 8'd3},  // R3 recharge
    '{OP_CLR,   6'b110000, 12'sd0,    1'b0, 2'b00, 8'd9},
    '{OP_START, 6'b110000, 12'sd0,    1'b0, 2'b00, 8'd7},
    '{OP_V,     6'b110000, 12'sd1400, 1'b0, 2'b00, 8'd7},
    '{OP_V,     6'b110001, 12'sd1300, 1'b0, 2'b00, 8'd7},  // R7 paused
    '{OP_V,     6'b110001, 12'sd1500, 1'b0, 2'b00, 8'd7},  // R7 peak frozen
    '{OP_V,     6'b110000, 12'sd1395, 1'b0, 2'b00, 8'd7},
    '{OP_V,     6'b110000, 12'sd1390, 1'b1, 2'b01, 8'd7},
    '{OP_CLR,   6'b110000, 12'sd0,    1'b0, 2'b00, 8'd9},
    '{OP_START, 6'b110000, 12'sd0,    1'b0, 2'b00, 8'd4},
    '{OP_T,     6'b110000, 12'sd250,  1'b0, 2'b00, 8'd4},
    '{OP_MIN,   6'b110000, 12'sd0,    1'b0, 2'b00, 8'd4},  // R4 ref only
    '{OP_T,     6'b110000, 12'sd259,  1'b0, 2'b00, 8'd4},
    '{OP_MIN,   6'b110000, 12'sd0,    1'b0, 2'b00, 8'd5},  // R5 NiMH 9
    '{OP_T,     6'b110000, 12'sd269,  1'b0, 2'b00, 8'd4},
    '{OP_MIN,   6'b110000, 12'sd0,    1'b1, 2'b10, 8'd4},  // R4 R5 10
    '{OP_CLR,   6'b110000, 12'sd0,    1'b0, 2'b00, 8'd9},
    '{OP_START, 6'b111000, 12'sd0,    1'b0, 2'b00, 8'd5},
    '{OP_T,     6'b111000, 12'sd300,  1'b0, 2'b00, 8'd5},
    '{OP_MIN,   6'b111000, 12'sd0,    1'b0, 2'b00, 8'd5},
    '{OP_T,     6'b111000, 12'sd314,  1'b0, 2'b00, 8'd5},
    '{OP_MIN,   6'b111000, 12'sd0,    1'b0, 2'b00, 8'd5},  // R5 early 14
    '{OP_T,     6'b111000, 12'sd329,  1'b0, 2'b00, 8'd5},
    '{OP_MIN,   6'b111000, 12'sd0,    1'b1, 2'b10, 8'd5},  // R5 early 15
    '{OP_CLR,   6'b111000, 12'sd0,    1'b0, 2'b00, 8'd9},
    '{OP_START, 6'b111010, 12'sd0,    1'b0, 2'b00, 8'd5},
    '{OP_T,     6'b111010, 12'sd300,  1'b0, 2'b00, 8'd5},
    '{OP_MIN,   6'b111010, 12'sd0,    1'b0, 2'b00, 8'd5},
    '{OP_T,     6'b111010, 12'sd310,  1'b0, 2'b00, 8'd5},
    '{OP_MIN,   6'b111010, 12'sd0,    1'b1, 2'b10, 8'd5},  // R5 recharge 10
    '{OP_CLR,   6'b111010, 12'sd0,    1'b0, 2'b00, 8'd9},
    '{OP_START, 6'b011000, 12'sd0,    1'b0, 2'b00, 8'd5},
    '{OP_T,     6'b011000, 12'sd300,  1'b0, 2'b00, 8'd5},
    '{OP_MIN,   6'b011000, 12'sd0,    1'b0, 2'b00, 8'd5},
    '{OP_T,     6'b011000, 12'sd319,  1'b0, 2'b00, 8'd5},
    '{OP_MIN,   6'b011000, 12'sd0,    1'b0, 2'b00, 8'd5},  // R5 NiCd 19
    '{OP_T,     6'b011000, 12'sd339,  1'b0, 2'b00, 8'd5},
    '{OP_MIN,   6'b011000, 12'sd0,    1'b1, 2'b10, 8'd5},  // R5 NiCd 20
    '{OP_CLR,   6'b011000, 12'sd0,    1'b0, 2'b00, 8'd9}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic start, chem, therm, pause, inih, stab, rchg, vv, tv, mn, clr;
  logic [SW-1:0] vcode;
  logic [TW-1:0] tcode;
  logic term;
  logic [1:0] rsn;
  int n_chk = 0, n_err = 0;

  always #2 clk = ~clk;

  nickel_term_detect #(.SW(SW), .TW(TW)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .chem_nimh_i(chem),
    .therm_i(therm), .pause_i(pause), .init_high_i(inih), .stab_i(stab),
    .from_rchg_i(rchg), .v_valid_i(vv), .v_code_i(vcode), .t_valid_i(tv),
    .t_code_i(tcode), .minute_i(mn), .clr_i(clr), .term_o(term), .reason_o(rsn)
  );

  task automatic check(input logic et, input logic [1:0] er, input string tag);
    n_chk++;
    if (term !== et || rsn !== er) begin
      n_err++;
      $display("FAIL %s: term=%0b reason=%02b expected term=%0b reason=%02b",
               tag, term, rsn, et, er);
    end
  endtask

  task automatic step(input logic [2:0] op, input logic [5:0] cfg,
                      input logic signed [11:0] val);
    @(negedge clk);
    {chem, therm, stab, inih, rchg, pause} = cfg;
    start = (op == OP_START);
    vv    = (op == OP_V) || (op == OP_VM) || (op == OP_VC);
    tv    = (op == OP_T);
    mn    = (op == OP_MIN) || (op == OP_VM);
    clr   = (op == OP_CLR) || (op == OP_VC);
    vcode = val;
    tcode = val[TW-1:0];
    @(posedge clk);
    #1;
  endtask

  initial begin
    #400000;
    n_err++;
    $display("FAIL watchdog: expired, expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end

  initial begin
    {start, chem, therm, pause, inih, stab, rchg, vv, tv, mn, clr} = '0;
    vcode = '0; tcode = '0;
    #10;
    check(1'b0, 2'b00, "R10 reset");
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      step(VEC[i].op, VEC[i].cfg, VEC[i].val);
      check(VEC[i].et, VEC[i].er, $sformatf("R%0d vector %0d", VEC[i].req, i));
    end

    // R6: no thermistor, large rise ignored
    step(OP_START, 6'b100000, 0);
    step(OP_T, 6'b100000, 300);
    step(OP_MIN, 6'b100000, 0);
    step(OP_T, 6'b100000, 400);
    step(OP_MIN, 6'b100000, 0);     check(1'b0, 2'b00, "R6 no thermistor");
    // R7: paused strobe keeps reference at 400
    step(OP_T, 6'b110001, 500);
    step(OP_MIN, 6'b110001, 0);     check(1'b0, 2'b00, "R7 paused minute");
    step(OP_MIN, 6'b110000, 0);     check(1'b1, 2'b10, "R7 resume slope");
    step(OP_CLR, 6'b110000, 0);
    // R8: both fire together, drop wins
    step(OP_START, 6'b110000, 0);
    step(OP_V, 6'b110000, 1400);
    step(OP_T, 6'b110000, 300);
    step(OP_MIN, 6'b110000, 0);
    step(OP_T, 6'b110000, 320);
    step(OP_VM, 6'b110000, 1390);   check(1'b1, 2'b01, "R8 priority");
    step(OP_IDLE, 6'b110000, 0);    check(1'b0, 2'b01, "R8 single pulse");
    step(OP_CLR, 6'b110000, 0);
    // R9: clear beats a firing sample
    step(OP_START, 6'b110000, 0);
    step(OP_V, 6'b110000, 1400);
    step(OP_VC, 6'b110000, 1300);   check(1'b0, 2'b00, "R9 clear wins");
    step(OP_V, 6'b110000, 1300);    check(1'b1, 2'b01, "R9 fires after clear");
    // R10: reset mid-run
    @(negedge clk); rst_n = 1'b0; #1;
    check(1'b0, 2'b00, "R10 async reset");
    @(negedge clk); rst_n = 1'b1;
    step(OP_V, 6'b110000, 1300);    check(1'b0, 2'b00, "R10 first sample loads");
    step(OP_V, 6'b110000, 1290);    check(1'b1, 2'b01, "R10 then drop");
    step(OP_IDLE, 6'b110000, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end
endmodule